// File: doc/BRIEF.md
# Host Port and VRAM Access Controller

This block is the processor-facing front end of a tile-based video display processor. An 8-bit host sees two ports: a data port and a command port. Through the command port the host loads a 14-bit VRAM pointer, writes one of eight write-only control registers, and reads a status byte. Through the data port the host streams bytes to VRAM, or from VRAM through a read-ahead buffer. The pointer steps forward by one after every such transfer.

Command-port writes come in pairs. A shared toggle records whether the next command write is a first or a second byte. Any other port access puts the toggle back to the first-byte state. The block holds the status flags. The display timing, pattern fetch and sprite logic set these flags by one-cycle pulses. The block also drives the active-low interrupt line. On the memory side it issues one request at a time to a single-port VRAM. While that request waits for its acknowledge, the block reports busy to the host.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, the host read data, every control register and the status flags are 0. The pointer is 0, `host_busy` is 0 and `int_n` is 1.
- R2: A first command write stores its byte. If the following command write has bits 7:6 = 01, the pointer becomes {second[5:0], first}. No VRAM cycle is started.
- R3: If a second command byte has bit 7 = 1, the first byte is written to control register second[2:0]. Bits 6:3 are ignored. The pointer is unchanged, and no other control register changes.
- R4: A data-port write stores its byte in VRAM at the pointer, with exactly one VRAM write cycle. The pointer then steps by one and wraps from 3FFFh to 0000h.
- R5: If a second command byte has bits 7:6 = 00, the pointer is loaded as in R2. One VRAM read of that address fills the read-ahead buffer, and the pointer becomes that address plus one.
- R6: A data-port read puts the buffered byte on `host_rdata` in the cycle after it is accepted. It then starts one VRAM read at the pointer into the buffer and steps the pointer.
- R7: Any data-port access, and any command-port read, returns the pair toggle to the first-byte state.
- R8: A command-port read returns {frame, fifth, collision, number[4:0]} on `host_rdata` in the next cycle. It clears the three flags and leaves the number unchanged.
- R9: A fifth-sprite pulse loads `fifth_num` into the number field only while the fifth flag is clear.
- R10: A flag-set pulse in the same cycle as a status read leaves that flag set after the read.
- R11: `int_n` is 0 exactly while the frame flag is 1 and control register 1 bit 5 is 1.
- R12: From acceptance until the cycle after `vram_ack`, `host_busy` is 1. During that time the request strobe and `vram_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access request, one cycle per access |
| host_sel | input | 1 | 0 selects the data port, 1 the command port |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after acceptance |
| host_busy | output | 1 | VRAM cycle outstanding; host must not access |
| vram_addr | output | 14 | VRAM request address |
| vram_wdata | output | 8 | VRAM write byte |
| vram_we | output | 1 | VRAM write request, held until acknowledge |
| vram_re | output | 1 | VRAM read request, held until acknowledge |
| vram_ack | input | 1 | One-cycle completion of the pending request |
| vram_rdata | input | 8 | VRAM read byte, valid with `vram_ack` |
| frame_pulse | input | 1 | Sets the frame flag |
| fifth_pulse | input | 1 | Sets the fifth-sprite flag |
| fifth_num | input | 5 | Sprite number that goes with `fifth_pulse` |
| coll_pulse | input | 1 | Sets the collision flag |
| ctrl_regs | output | 64 | Control registers, register n at bits 8n+7:8n |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The checks assume that the host presents no access while `host_busy` is high. They also assume that `vram_ack` arrives only for a pending request, and that control register 1 is never rewritten in the same cycle as a frame pulse. The bench's host task waits for `host_busy` to fall before it drives anything. Its memory model acknowledges only a strobe it has not yet answered, one cycle after that strobe appears. Flag pulses are driven alone, except in the single test that deliberately lines up a frame pulse with a status read.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;
  localparam int unsigned HOST_W     = 8;
  localparam int unsigned STAT_FRAME = 7;
  localparam int unsigned STAT_FIFTH = 6;
  localparam int unsigned STAT_COLL  = 5;
  localparam int unsigned NUM_W      = 5;
  localparam int unsigned IE_REG     = 1;
  localparam int unsigned IE_BIT     = 5;
  typedef logic [HOST_W-1:0] hbyte_t;
endpackage

// File: rtl/vdp_cmd_seq.sv
module vdp_cmd_seq
  import vdp_host_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned REG_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 sel_cmd,
  input  logic                 we,
  input  hbyte_t               wdata,
  output logic                 addr_load,
  output logic                 addr_read,
  output logic [ADDR_W-1:0]    addr_value,
  output logic                 reg_wr,
  output logic [REG_SEL_W-1:0] reg_idx,
  output hbyte_t               reg_val
);
  localparam int unsigned HI_W = ADDR_W - HOST_W;

  logic   second_q, second_nx;
  hbyte_t first_q, first_nx;
  logic   cmd_wr, pair_done;

  assign cmd_wr    = acc && sel_cmd && we;
  assign pair_done = cmd_wr && second_q;

  always_comb begin
    second_nx = second_q;
    first_nx  = first_q;
    if (acc) begin
      second_nx = cmd_wr ? !second_q : 1'b0;
      if (cmd_wr && !second_q) first_nx = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      first_q  <= '0;
    end else begin
      second_q <= second_nx;
      first_q  <= first_nx;
    end
  end

  assign addr_load  = pair_done && !wdata[7];
  assign addr_read  = !wdata[6];
  assign addr_value = {wdata[HI_W-1:0], first_q};
  assign reg_wr     = pair_done && wdata[7];
  assign reg_idx    = wdata[REG_SEL_W-1:0];
  assign reg_val    = first_q;
endmodule

// File: rtl/vdp_ctrl_regs.sv
module vdp_ctrl_regs
  import vdp_host_pkg::*;
#(
  parameter int unsigned REG_CNT   = 8,
  parameter int unsigned REG_SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [REG_SEL_W-1:0]        idx,
  input  hbyte_t                      val,
  output logic [REG_CNT*HOST_W-1:0]   regs_flat
);
  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    logic   hit;
    hbyte_t q;
    assign hit = wr && (idx == REG_SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= val;
    end
    assign regs_flat[i*HOST_W +: HOST_W] = q;
  end
endmodule

// File: rtl/vdp_vram_port.sv
module vdp_vram_port
  import vdp_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_data,
  input  logic              data_we,
  input  hbyte_t            wdata,
  input  logic              addr_load,
  input  logic              addr_read,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              vram_ack,
  input  hbyte_t            vram_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] vram_addr,
  output hbyte_t            vram_wdata,
  output logic              vram_we,
  output logic              vram_re,
  output hbyte_t            rbuf
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_nx, req_q, req_nx, base;
  logic              pend_q, pend_nx, rw_q, rw_nx;
  hbyte_t            wd_q, wd_nx, buf_q, buf_nx;
  logic              start_rd, start_wr;

  assign start_rd = (acc_data && !data_we) || (addr_load && addr_read);
  assign start_wr = acc_data && data_we;
  assign base     = addr_load ? addr_value : ptr_q;

  always_comb begin
    ptr_nx  = ptr_q;
    req_nx  = req_q;
    pend_nx = pend_q;
    rw_nx   = rw_q;
    wd_nx   = wd_q;
    buf_nx  = buf_q;
    if (start_rd || start_wr) begin
      req_nx  = base;
      ptr_nx  = base + ONE;
      pend_nx = 1'b1;
      rw_nx   = start_wr;
      if (start_wr) wd_nx = wdata;
    end else if (addr_load) begin
      ptr_nx = addr_value;
    end
    if (pend_q && vram_ack) begin
      pend_nx = 1'b0;
      if (!rw_q) buf_nx = vram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      req_q  <= '0;
      pend_q <= 1'b0;
      rw_q   <= 1'b0;
      wd_q   <= '0;
      buf_q  <= '0;
    end else begin
      ptr_q  <= ptr_nx;
      req_q  <= req_nx;
      pend_q <= pend_nx;
      rw_q   <= rw_nx;
      wd_q   <= wd_nx;
      buf_q  <= buf_nx;
    end
  end

  assign busy       = pend_q;
  assign vram_addr  = req_q;
  assign vram_wdata = wd_q;
  assign vram_we    = pend_q && rw_q;
  assign vram_re    = pend_q && !rw_q;
  assign rbuf       = buf_q;
endmodule

// File: rtl/vdp_status_flags.sv
module vdp_status_flags
  import vdp_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic             frame_set,
  input  logic             fifth_set,
  input  logic [NUM_W-1:0] fifth_num,
  input  logic             coll_set,
  output hbyte_t           status,
  output logic             frame_flag
);
  logic             frame_q, frame_nx, fifth_q, fifth_nx, coll_q, coll_nx;
  logic [NUM_W-1:0] num_q, num_nx;

  always_comb begin
    frame_nx = frame_set || (frame_q && !rd_clr);
    fifth_nx = fifth_set || (fifth_q && !rd_clr);
    coll_nx  = coll_set  || (coll_q  && !rd_clr);
    num_nx   = (fifth_set && !fifth_q) ? fifth_num : num_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      fifth_q <= 1'b0;
      coll_q  <= 1'b0;
      num_q   <= '0;
    end else begin
      frame_q <= frame_nx;
      fifth_q <= fifth_nx;
      coll_q  <= coll_nx;
      num_q   <= num_nx;
    end
  end

  always_comb begin
    status             = '0;
    status[STAT_FRAME] = frame_q;
    status[STAT_FIFTH] = fifth_q;
    status[STAT_COLL]  = coll_q;
    status[NUM_W-1:0]  = num_q;
  end
  assign frame_flag = frame_q;
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
  import vdp_host_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned REG_CNT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_cs,
  input  logic                      host_sel,
  input  logic                      host_we,
  input  logic [7:0]                host_wdata,
  output logic [7:0]                host_rdata,
  output logic                      host_busy,
  output logic [ADDR_W-1:0]         vram_addr,
  output logic [7:0]                vram_wdata,
  output logic                      vram_we,
  output logic                      vram_re,
  input  logic                      vram_ack,
  input  logic [7:0]                vram_rdata,
  input  logic                      frame_pulse,
  input  logic                      fifth_pulse,
  input  logic [4:0]                fifth_num,
  input  logic                      coll_pulse,
  output logic [REG_CNT*8-1:0]      ctrl_regs,
  output logic                      int_n
);
  localparam int unsigned REG_SEL_W = $clog2(REG_CNT);

  logic                 acc, acc_data, stat_rd;
  logic                 addr_load, addr_read, reg_wr, frame_flag;
  logic [ADDR_W-1:0]    addr_value;
  logic [REG_SEL_W-1:0] reg_idx;
  hbyte_t               reg_val, rbuf, status, rdata_q, rdata_nx;

  assign acc      = host_cs && !host_busy;
  assign acc_data = acc && !host_sel;
  assign stat_rd  = acc && host_sel && !host_we;

  vdp_cmd_seq #(.ADDR_W(ADDR_W), .REG_SEL_W(REG_SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel_cmd(host_sel), .we(host_we),
    .wdata(host_wdata), .addr_load(addr_load), .addr_read(addr_read),
    .addr_value(addr_value), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_val(reg_val)
  );

  vdp_ctrl_regs #(.REG_CNT(REG_CNT), .REG_SEL_W(REG_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .val(reg_val),
    .regs_flat(ctrl_regs)
  );

  vdp_vram_port #(.ADDR_W(ADDR_W)) u_vram (
    .clk(clk), .rst_n(rst_n), .acc_data(acc_data), .data_we(host_we),
    .wdata(host_wdata), .addr_load(addr_load), .addr_read(addr_read),
    .addr_value(addr_value), .vram_ack(vram_ack), .vram_rdata(vram_rdata),
    .busy(host_busy), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .vram_we(vram_we), .vram_re(vram_re), .rbuf(rbuf)
  );

  vdp_status_flags u_stat (
    .clk(clk), .rst_n(rst_n), .rd_clr(stat_rd), .frame_set(frame_pulse),
    .fifth_set(fifth_pulse), .fifth_num(fifth_num), .coll_set(coll_pulse),
    .status(status), .frame_flag(frame_flag)
  );

  always_comb begin
    rdata_nx = rdata_q;
    if (acc && !host_we) rdata_nx = host_sel ? status : rbuf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nx;
  end

  assign host_rdata = rdata_q;
  assign int_n      = !(frame_flag && ctrl_regs[IE_REG*8 + IE_BIT]);
endmodule

// File: rtl/vdp_host_port_chk.sv
module vdp_host_port_chk #(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned REG_CNT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_cs,
  input logic                 host_sel,
  input logic                 host_we,
  input logic                 host_busy,
  input logic [ADDR_W-1:0]    vram_addr,
  input logic                 vram_we,
  input logic                 vram_re,
  input logic                 vram_ack,
  input logic                 frame_pulse,
  input logic [REG_CNT*8-1:0] ctrl_regs,
  input logic                 int_n
);
  logic acc_c, cmd_wr_c, stat_rd_c;
  assign acc_c     = host_cs && !host_busy;
  assign cmd_wr_c  = acc_c && host_sel && host_we;
  assign stat_rd_c = acc_c && host_sel && !host_we;

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_we && vram_re));

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we || vram_re) && !vram_ack |=> (vram_we || vram_re) && $stable(vram_addr));

  assert_req_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    vram_ack |=> !(vram_we || vram_re) && !host_busy);

  assert_data_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c && !host_sel |=> host_busy && (vram_we || vram_re));

  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_c |=> $stable(ctrl_regs));

  assert_read_releases_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_c && !frame_pulse |=> int_n);

  assert_frame_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse && ctrl_regs[13] && !cmd_wr_c |=> !int_n);
endmodule

bind vdp_host_port vdp_host_port_chk #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_chk (.*);

// File: tb/vdp_host_port_bench.sv
module vdp_host_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0, host_sel = 1'b0, host_we = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_busy;
  logic [13:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic        vram_we, vram_re;
  logic        vram_ack;
  logic [7:0]  vram_rdata;
  logic        frame_pulse = 1'b0, fifth_pulse = 1'b0, coll_pulse = 1'b0;
  logic [4:0]  fifth_num = '0;
  logic [63:0] ctrl_regs;
  logic        int_n;

  int tests = 0, fails = 0, acks = 0, cycles = 0;
  logic [7:0] mem [1024];

  always #5 clk = ~clk;

  vdp_host_port u_vdp_host_port (.*);

  // VRAM model: acknowledges a pending strobe one cycle after it appears
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vram_ack   <= 1'b0;
      vram_rdata <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if ((vram_we || vram_re) && !vram_ack) begin
      vram_ack   <= 1'b1;
      vram_rdata <= mem[vram_addr[9:0]];
      if (vram_we) mem[vram_addr[9:0]] <= vram_wdata;
    end else begin
      vram_ack <= 1'b0;
    end
  end

  always @(posedge clk) if (vram_ack) acks++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic s, input logic w, input logic [7:0] d, output logic [7:0] r);
    while (host_busy) @(negedge clk);
    host_cs = 1'b1; host_sel = s; host_we = w; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0;
    r = host_rdata;
    while (host_busy) @(negedge clk);
  endtask

  task automatic pulse(input logic f, input logic v, input logic c, input logic [4:0] n);
    frame_pulse = f; fifth_pulse = v; coll_pulse = c; fifth_num = n;
    @(negedge clk);
    frame_pulse = 1'b0; fifth_pulse = 1'b0; coll_pulse = 1'b0;
  endtask

  // {sel, we, chk, data, expected}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 8'h20, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h81, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h10, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h40, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hAA, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hBB, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hCC, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h10, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'hAA},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'hBB},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'hCC},
    {1'b1, 1'b1, 1'b0, 8'h0F, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h87, 8'h00}
  };

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] r;
    int a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 regs", ctrl_regs, 64'h0);
    check("R1 busy", host_busy, 1'b0);
    check("R1 int_n", int_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 write pointer, R4 writes, R5 read setup, R6 reads, R3 regs
    a0 = acks;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][18], VEC[i][17], VEC[i][15:8], r);
      if (VEC[i][16]) check("R6 read-ahead data", r, VEC[i][7:0]);
    end
    check("R2/R4 stored byte", mem[16], 8'hAA);
    check("R12 one VRAM cycle per access", acks - a0, 7);
    check("R3 reg1", ctrl_regs[15:8], 8'h20);
    check("R3 reg7", ctrl_regs[63:56], 8'h0F);

    // R12 / R4: busy sequencing and address of a single write
    access(1, 1, 8'h20, r); access(1, 1, 8'h40, r);
    access(1, 1, 8'h5A, r); access(1, 1, 8'hFA, r);   // R3: bits 6:3 ignored, reg 2
    check("R3 reg2 value", ctrl_regs[23:16], 8'h5A);
    check("R3 reg7 untouched", ctrl_regs[63:56], 8'h0F);
    host_cs = 1'b1; host_sel = 1'b0; host_we = 1'b1; host_wdata = 8'h5C;
    @(negedge clk); host_cs = 1'b0;
    check("R12 busy after accept", host_busy, 1'b1);
    check("R3 pointer kept across reg write", vram_addr, 14'h0020);
    check("R4 write strobe", vram_we, 1'b1);
    @(negedge clk);
    check("R12 busy during ack", host_busy, 1'b1);
    check("R12 addr held", vram_addr, 14'h0020);
    @(negedge clk);
    check("R12 busy released", host_busy, 1'b0);
    check("R4 byte written", mem[32], 8'h5C);

    // R7: data access resets the pair toggle
    access(1, 1, 8'h55, r); access(0, 0, 8'h00, r);
    access(1, 1, 8'h30, r); access(1, 1, 8'h40, r);
    access(0, 1, 8'h77, r);
    check("R7 toggle reset by data read", mem[48], 8'h77);
    // R7: command read resets the pair toggle
    access(1, 1, 8'h66, r); access(1, 0, 8'h00, r);
    access(1, 1, 8'h31, r); access(1, 1, 8'h40, r);
    access(0, 1, 8'h88, r);
    check("R7 toggle reset by status read", mem[49], 8'h88);

    // R4 wrap, R5 read setup at top of space
    access(1, 1, 8'hFF, r); access(1, 1, 8'h7F, r);
    access(0, 1, 8'h11, r); access(0, 1, 8'h22, r);
    check("R4 top byte", mem[1023], 8'h11);
    check("R4 wrapped byte", mem[0], 8'h22);
    access(1, 1, 8'hFF, r); access(1, 1, 8'h3F, r);
    access(0, 0, 8'h00, r);
    check("R5 prefetch at 3FFF", r, 8'h11);
    access(0, 0, 8'h00, r);
    check("R5 wrapped read", r, 8'h22);

    // R8 / R11 frame flag and interrupt
    access(1, 0, 8'h00, r);
    check("R11 idle int_n", int_n, 1'b1);
    pulse(1, 0, 0, 5'd0);
    check("R11 int asserted", int_n, 1'b0);
    access(1, 0, 8'h00, r);
    check("R8 frame status", r, 8'h80);
    check("R11 int released", int_n, 1'b1);
    access(1, 0, 8'h00, r);
    check("R8 flags cleared", r, 8'h00);
    access(1, 1, 8'h00, r); access(1, 1, 8'h81, r);
    pulse(1, 0, 0, 5'd0);
    check("R11 masked int", int_n, 1'b1);
    access(1, 0, 8'h00, r);
    check("R8 frame without enable", r, 8'h80);

    // R9 fifth-sprite number capture
    pulse(0, 1, 0, 5'd7);
    pulse(0, 1, 0, 5'd3);
    access(1, 0, 8'h00, r);
    check("R9 first number kept", r, 8'h47);
    pulse(0, 0, 1, 5'd0);
    access(1, 0, 8'h00, r);
    check("R8 collision and held number", r, 8'h27);
    pulse(0, 1, 0, 5'd9);
    access(1, 0, 8'h00, r);
    check("R9 new number after clear", r, 8'h49);

    // R10 set wins over read clear
    host_cs = 1'b1; host_sel = 1'b1; host_we = 1'b0; frame_pulse = 1'b1;
    @(negedge clk); host_cs = 1'b0; frame_pulse = 1'b0;
    check("R10 read value during set", host_rdata, 8'h09);
    access(1, 0, 8'h00, r);
    check("R10 flag survived", r, 8'h89);
    access(1, 0, 8'h00, r);
    check("R10 cleared afterwards", r, 8'h09);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule